// File: doc/BRIEF.md
# General-Purpose Compare/Capture Timer

This block is a 16-bit event timer. A small register bus configures it and observes it. A selectable clock source drives an 8-bit prescaler, and the prescaler advances the counter. The source is the system clock, the system clock divided by a fixed ratio, or a synchronised external clock. The counter either runs freely and wraps, or it returns to zero right after it reaches a programmed reference value.

A reference match sets a sticky flag and can drive the output pin, either as a toggle or as a one-cycle pulse. A chosen edge on the capture input copies the current count into a capture register and sets a second sticky flag. Software clears either flag by writing a one to it. One interrupt line combines the two flags, each one gated by its own enable.

Register map (word addresses on the bus):

- 0: mode.
- 1: reference.
- 2: capture, read only.
- 3: counter. A write clears it.
- 4: event flags. Bit 0 is the capture flag and bit 1 is the reference flag.
- 5: reference-interrupt enable, bit 0.

Mode fields:

- 15:8: prescale.
- 7:6: capture edge.
- 5:4: output mode.
- 3: restart.
- 2:1: clock source.
- 0: enable.

Top module: `gp_timer`

## Requirements
- R1: After reset every register reads zero, `tmr_out` is 0 and `irq` is 0.
- R2: With clock source 01 (system clock), the counter advances once every prescale+1 enabled cycles. The prescale sits in mode bits 15:8.
- R3: With clock source 10, the counter advances once every 16*(prescale+1) enabled cycles.
- R4: With clock source 11, the counter advances once every prescale+1 rising edges of `ext_clk`, after a two-flop synchroniser.
- R5: While mode bit 0 is 0, or the clock source is 00, the count holds its value.
- R6: With mode bit 3 set to 1, the next count after the reference value is 0. With bit 3 set to 0, the count passes the reference and wraps from 0xFFFF to 0x0000.
- R7: When the count reaches the reference value, event bit 1 is set.
- R8: Output mode (bits 5:4) 10 inverts `tmr_out` on each match. Mode 01 drives `tmr_out` high for exactly one cycle after each match. Mode 00 keeps `tmr_out` low.
- R9: Capture-edge field (bits 7:6) 01 captures on a rising edge of `cap_in`, 10 on a falling edge and 11 on either edge. Each capture copies the count into the capture register and sets event bit 0. Field 00 ignores the input.
- R10: Writing 1 to an event bit clears it and writing 0 leaves it unchanged. Event bits 15:2 read as zero.
- R11: `irq` is high when the capture flag is set with a nonzero capture-edge field, or when the reference flag is set with the reference-interrupt enable set.
- R12: A write to the counter register sets the count to zero and restarts the prescale and divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture input, asynchronous |
| tmr_out | output | 1 | Reference-match output pin |
| irq | output | 1 | Interrupt request |

## Verification
A table of configurations runs the counter for a fixed number of cycles and checks the final count. The table covers:

- several prescale values, which separate a divide of one from wider divides;
- the divided source against the undivided one;
- the stopped source;
- restart against free-run with the same reference, which tells a wrap at the reference from a pass through it.

Directed runs then cover the remaining behaviour:

- the 0xFFFF wrap;
- toggle, pulse and silent output modes on the same match sequence;
- each capture-edge setting, driven with both polarities so that each edge that should be ignored is shown to be ignored;
- external-clock counting;
- the effect of one-bit and zero-bit writes on the event flags and on `irq`.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;
    localparam int CNT_W  = 16;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RIE  = 3'd5;

    localparam int EV_CAP = 0;
    localparam int EV_REF = 1;

    typedef enum logic [1:0] {SRC_OFF = 2'd0, SRC_SYS = 2'd1, SRC_DIV = 2'd2, SRC_EXT = 2'd3} src_e;
    typedef enum logic [1:0] {OUT_OFF = 2'd0, OUT_PULSE = 2'd1, OUT_TOGGLE = 2'd2, OUT_RSVD = 2'd3} omode_e;
    typedef enum logic [1:0] {EDGE_OFF = 2'd0, EDGE_RISE = 2'd1, EDGE_FALL = 2'd2, EDGE_ANY = 2'd3} edge_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        edge_e            cap_edge;
        omode_e           omode;
        logic             restart;
        src_e             src;
        logic             en;
    } mode_t;

    function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                    input logic [CNT_W-1:0] lim,
                                                    input logic restart);
        if (restart && cur == lim) return '0;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/gp_timer_edge.sv
module gp_timer_edge import gp_timer_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    input  edge_e sel,
    output logic  hit
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sync_q[i] <= 1'b0;
            else if (i == 0) sync_q[i] <= din;
            else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    logic rise, fall;
    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
    assign hit  = (sel[0] & rise) | (sel[1] & fall);
endmodule

// File: rtl/gp_timer_tick.sv
module gp_timer_tick import gp_timer_pkg::*; #(
    parameter int DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  src_e src,
    input  logic ext_hit,
    output logic tick
);
    localparam int DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_RATIO - 1);

    logic [DW-1:0] div_q;
    logic          div_last;
    assign div_last = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)                div_q <= '0;
        else if (en && src == SRC_DIV) div_q <= div_last ? '0 : div_q + 1'b1;
    end

    always_comb begin
        case (src)
            SRC_SYS: tick = en;
            SRC_DIV: tick = en && div_last;
            SRC_EXT: tick = en && ext_hit;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/gp_timer_prescale.sv
module gp_timer_prescale import gp_timer_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [PSC_W-1:0] limit,
    output logic             cnt_en
);
    logic [PSC_W-1:0] psc_q;
    logic             wrap;
    assign wrap   = (psc_q >= limit);
    assign cnt_en = tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) psc_q <= '0;
        else if (tick)  psc_q <= wrap ? '0 : psc_q + 1'b1;
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer import gp_timer_pkg::*; #(
    parameter int DIV_RATIO   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q, cap_q, cnt_q, cnt_nxt;
    logic             ev_cap, ev_ref, rie_q, tog_q, pls_q;
    logic             wr_mode, wr_ref, wr_cnt, wr_evt, wr_rie;
    logic             ext_hit, cap_hit, tick, cnt_en, hit;

    assign wr_mode = bus_wr && bus_addr == A_MODE;
    assign wr_ref  = bus_wr && bus_addr == A_REF;
    assign wr_cnt  = bus_wr && bus_addr == A_CNT;
    assign wr_evt  = bus_wr && bus_addr == A_EVT;
    assign wr_rie  = bus_wr && bus_addr == A_RIE;

    gp_timer_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk), .sel(EDGE_RISE), .hit(ext_hit));

    gp_timer_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst(rst), .din(cap_in), .sel(mode_q.cap_edge), .hit(cap_hit));

    gp_timer_tick #(.DIV_RATIO(DIV_RATIO)) u_tick (
        .clk(clk), .rst(rst), .clr(wr_cnt), .en(mode_q.en), .src(mode_q.src),
        .ext_hit(ext_hit), .tick(tick));

    gp_timer_prescale u_psc (
        .clk(clk), .rst(rst), .clr(wr_cnt), .tick(tick), .limit(mode_q.psc),
        .cnt_en(cnt_en));

    assign cnt_nxt = next_count(cnt_q, ref_q, mode_q.restart);
    assign hit     = cnt_en && !wr_cnt && cnt_nxt == ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ref_q  <= '0;
            cap_q  <= '0;
            cnt_q  <= '0;
            ev_cap <= 1'b0;
            ev_ref <= 1'b0;
            rie_q  <= 1'b0;
            tog_q  <= 1'b0;
            pls_q  <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= mode_t'(bus_wdata);
            if (wr_ref)  ref_q  <= bus_wdata;
            if (wr_rie)  rie_q  <= bus_wdata[0];
            if (wr_cnt)      cnt_q <= '0;
            else if (cnt_en) cnt_q <= cnt_nxt;
            if (cap_hit) cap_q <= cnt_q;
            ev_cap <= cap_hit || (ev_cap && !(wr_evt && bus_wdata[EV_CAP]));
            ev_ref <= hit     || (ev_ref && !(wr_evt && bus_wdata[EV_REF]));
            tog_q  <= tog_q ^ (hit && mode_q.omode == OUT_TOGGLE);
            pls_q  <= hit && mode_q.omode == OUT_PULSE;
        end
    end

    always_comb begin
        case (mode_q.omode)
            OUT_TOGGLE: tmr_out = tog_q;
            OUT_PULSE:  tmr_out = pls_q;
            default:    tmr_out = 1'b0;
        endcase
    end

    assign irq = (ev_cap && mode_q.cap_edge != EDGE_OFF) || (ev_ref && rie_q);

    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = mode_q;
            A_REF:   bus_rdata = ref_q;
            A_CAP:   bus_rdata = cap_q;
            A_CNT:   bus_rdata = cnt_q;
            A_EVT:   bus_rdata = CNT_W'({ev_ref, ev_cap});
            A_RIE:   bus_rdata = CNT_W'(rie_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk import gp_timer_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input src_e             src,
    input logic             restart,
    input edge_e            cap_edge,
    input omode_e           omode,
    input logic             wr_cnt,
    input logic             cnt_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ref_v,
    input logic             ev_cap,
    input logic             ev_ref,
    input logic             tmr_out,
    input logic             irq
);
    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        ((!en || src == SRC_OFF) && !wr_cnt) |=> $stable(cnt));

    assert_restart_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !wr_cnt && restart && cnt == ref_v) |=> (cnt == '0));

    assert_clear_on_write_R12: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == '0));

    assert_capture_needs_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_cap) |-> ($past(cap_edge) != EDGE_OFF));

    assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_cap || ev_ref));

    assert_pulse_follows_step_R8: assert property (@(posedge clk) disable iff (rst)
        (omode == OUT_PULSE && tmr_out) |-> $past(cnt_en && !wr_cnt));
endmodule

bind gp_timer gp_timer_chk u_chk (
    .clk(clk), .rst(rst), .en(mode_q.en), .src(mode_q.src), .restart(mode_q.restart),
    .cap_edge(mode_q.cap_edge), .omode(mode_q.omode), .wr_cnt(wr_cnt), .cnt_en(cnt_en),
    .cnt(cnt_q), .ref_v(ref_q), .ev_cap(ev_cap), .ev_ref(ev_ref), .tmr_out(tmr_out),
    .irq(irq));

// File: tb/sim_gp_timer.sv
`timescale 1ns/1ps
module sim_gp_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic        tmr_out, irq;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    gp_timer u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq));

    // {mode, reference, cycles, expected count}
    localparam logic [63:0] VEC [9] = '{
        {16'h0003, 16'hFFFF, 16'd10,  16'd10},  // R2 divide by 1
        {16'h0303, 16'hFFFF, 16'd10,  16'd2},   // R2 divide by 4
        {16'hFF03, 16'hFFFF, 16'd600, 16'd2},   // R2 divide by 256
        {16'h000B, 16'h0004, 16'd12,  16'd2},   // R6 restart at 4
        {16'h0003, 16'h0004, 16'd12,  16'd12},  // R6 free-run passes reference
        {16'h000B, 16'h0000, 16'd7,   16'd0},   // R6 restart at zero
        {16'h0005, 16'hFFFF, 16'd40,  16'd2},   // R3 divide by 16
        {16'h0105, 16'hFFFF, 16'd70,  16'd2},   // R3 divide by 32
        {16'h0001, 16'hFFFF, 16'd20,  16'd0}    // R5 stopped source
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] mode, input logic [15:0] refv);
        wr(3'd0, mode & 16'hFFFE);
        wr(3'd1, refv);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0003);
        wr(3'd0, mode);
    endtask

    task automatic wait_cap;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register reset", v, 16'h0000);
        end
        check("R1 tmr_out reset", {15'd0, tmr_out}, 16'd0);
        check("R1 irq reset", {15'd0, irq}, 16'd0);

        for (int i = 0; i < 9; i++) begin
            setup(VEC[i][63:48], VEC[i][47:32]);
            repeat (int'(VEC[i][31:16])) @(posedge clk);
            @(negedge clk);
            rd(3'd3, v);
            check("R2/R3/R5/R6 table count", v, VEC[i][15:0]);
        end

        // R6 wrap and R7 reference flag
        setup(16'h0003, 16'h0005);
        repeat (65535) @(posedge clk);
        @(negedge clk);
        rd(3'd3, v); check("R6 count at 0xFFFF", v, 16'hFFFF);
        @(negedge clk);
        rd(3'd3, v); check("R6 wrap to zero", v, 16'h0000);
        rd(3'd4, v); check("R7 reference flag set", v, 16'h0002);

        // R8 toggle
        setup(16'h002B, 16'h0003);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R8 toggle high", {15'd0, tmr_out}, 16'd1);
        rd(3'd4, v); check("R7 flag on match", v, 16'h0002);
        check("R11 irq gated by enable", {15'd0, irq}, 16'd0);
        repeat (4) @(posedge clk); @(negedge clk);
        check("R8 toggle low", {15'd0, tmr_out}, 16'd0);
        wr(3'd0, 16'h002A);
        wr(3'd5, 16'h0001);
        check("R11 irq from reference", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); check("R10 zero write keeps", v, 16'h0002);
        wr(3'd4, 16'h0002);
        rd(3'd4, v); check("R10 one write clears", v, 16'h0000);
        check("R11 irq drops", {15'd0, irq}, 16'd0);
        wr(3'd5, 16'h0000);

        // R8 pulse and off
        setup(16'h001B, 16'h0003);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R8 pulse high", {15'd0, tmr_out}, 16'd1);
        @(negedge clk);
        check("R8 pulse one cycle", {15'd0, tmr_out}, 16'd0);
        setup(16'h000B, 16'h0003);
        repeat (3) @(posedge clk); @(negedge clk);
        check("R8 output off", {15'd0, tmr_out}, 16'd0);

        // R9 capture
        setup(16'h0043, 16'hFFFF);
        repeat (9) @(posedge clk);
        wr(3'd0, 16'h0042);
        rd(3'd3, v); check("R5 count after disable", v, 16'd10);
        cap_in = 1'b1; wait_cap;
        rd(3'd2, v); check("R9 rising capture value", v, 16'd10);
        rd(3'd4, v); check("R9 capture flag", v, 16'h0001);
        check("R11 irq from capture", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h0001);
        cap_in = 1'b0; wait_cap;
        rd(3'd4, v); check("R9 falling ignored in rise mode", v, 16'h0000);
        wr(3'd0, 16'h0082);
        cap_in = 1'b1; wait_cap;
        rd(3'd4, v); check("R9 rising ignored in fall mode", v, 16'h0000);
        cap_in = 1'b0; wait_cap;
        rd(3'd4, v); check("R9 falling capture", v, 16'h0001);
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h00C2);
        cap_in = 1'b1; wait_cap;
        rd(3'd4, v); check("R9 any mode rising", v, 16'h0001);
        wr(3'd4, 16'h0001);
        cap_in = 1'b0; wait_cap;
        rd(3'd4, v); check("R9 any mode falling", v, 16'h0001);
        wr(3'd4, 16'h0001);
        wr(3'd0, 16'h0002);
        cap_in = 1'b1; wait_cap;
        rd(3'd4, v); check("R9 capture off ignores", v, 16'h0000);
        check("R11 no irq capture off", {15'd0, irq}, 16'd0);
        cap_in = 1'b0; wait_cap;

        // R10 upper bits zero with both flags
        setup(16'h00CB, 16'h0002);
        cap_in = 1'b1; wait_cap;
        wr(3'd0, 16'h00CA);
        rd(3'd4, v); check("R10 both flags only low bits", v, 16'h0003);
        cap_in = 1'b0; wait_cap;

        // R4 external clock
        setup(16'h0007, 16'hFFFF);
        for (int k = 0; k < 5; k++) begin
            ext_clk = 1'b1; repeat (3) @(negedge clk);
            ext_clk = 1'b0; repeat (3) @(negedge clk);
        end
        wait_cap;
        rd(3'd3, v); check("R4 external edges counted", v, 16'd5);

        // R12 counter write while running
        setup(16'h0003, 16'hFFFF);
        repeat (20) @(posedge clk);
        wr(3'd3, 16'h1234);
        rd(3'd3, v); check("R12 write clears count", v, 16'h0000);
        repeat (5) @(posedge clk); @(negedge clk);
        rd(3'd3, v); check("R12 counts from zero", v, 16'd5);
        wr(3'd0, 16'h0002);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule